// File: doc/BRIEF.md
# Adaptive PWM Controller for a Switching Battery Supply

This block is the digital side of a switching regulator that generates a battery rail. It runs from one fixed system clock. It produces a drive pulse once per period, and a period register sets the length of that period. The pulse opens a switch in an external power stage. A one-bit comparator reports whether the regulated rail sits below its target. At the end of every period the controller uses that bit to widen or narrow the pulse by one clock.

The pulse width never grows so far that the off-time falls under a programmed minimum. That minimum is a 5-bit field plus four clocks. A second comparator flags an overload. When it does, the drive drops in the same cycle and stays low until the next period begins.

A calibration request opens a window of a fixed number of periods. During that window the overload flag is not acted on. A power-down input holds the whole loop idle and returns it to zero width, so that every restart begins as a soft start. The drive appears on two pins of opposite polarity, and the current width is brought out for reading.

Top module: `bsr_pwm_ctrl`

## Requirements
- R1: While `pwr_down` is 1, `drv_p` is 0, `drv_n` is 1 and `width_o` is 0 from the next clock edge onward. After `pwr_down` returns to 0, the period counter starts from zero and `width_o` climbs from 0.
- R2: One switching period lasts `period_cfg + 1` clocks. Rising edges of `drv_p` at a stable nonzero width are exactly that many clocks apart.
- R3: Within a period, `drv_p` is 1 for the first `width_o` clocks and 0 for the rest, provided no overload cut is active.
- R4: `width_o` changes only at the last clock of a period. It rises by 1 if `fb_low` is 1 in that clock, and falls by 1 if `fb_low` is 0. It never goes below 0.
- R5: `width_o` never exceeds `period_cfg + 1 - (off_cfg + 4)`. When that value is negative, the ceiling is 0.
- R6: `drv_n` is always the inverse of `drv_p`.
- R7: In any clock where `ovl` is 1 and no calibration is running, `drv_p` is 0 in that same clock and stays 0 until the current period ends. The pulse returns at full width in the next period.
- R8: A one-clock `cal_req` pulse sets `cal_busy`. `cal_busy` clears after `CAL_N` period ends have passed. While `cal_busy` is 1, `ovl` has no effect on `drv_p`.
- R9: After reset, `drv_p` is 0, `drv_n` is 1, `width_o` is 0 and `cal_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_down | input | 1 | 1 holds the controller idle and off |
| period_cfg | input | PER_W | Period length minus one, in clocks |
| off_cfg | input | OFF_W | Minimum off-time minus four, in clocks |
| cal_req | input | 1 | One-clock request to start a calibration window |
| fb_low | input | 1 | Comparator: 1 when the regulated rail is below target |
| ovl | input | 1 | Comparator: 1 when the power stage is overloaded |
| drv_p | output | 1 | Switch drive, 1 = switch on |
| drv_n | output | 1 | Inverse of `drv_p` |
| width_o | output | PER_W | Current pulse width in clocks (read-only) |
| cal_busy | output | 1 | Calibration window in progress |

## Verification
The bench builds the block with its default parameters: an 8-bit period register, a 5-bit off-time field and a four-period calibration window. It then programs short periods of 10 and 20 clocks. With such short periods, ramping up, saturating at the ceiling, ramping down to the zero floor, and running out a full calibration window each take only a few hundred clocks. Setting the off-time field to 10 against a 20-clock period moves the ceiling well below the period. This separates the clamp set by the minimum off-time from the plain period limit.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    localparam int BSR_PER_W     = 8;
    localparam int BSR_OFF_W     = 5;
    localparam int BSR_CAL_N     = 4;
    localparam int BSR_MOFF_BIAS = 4;
endpackage

// File: rtl/bsr_period_timer.sv
module bsr_period_timer #(
    parameter int PER_W = bsr_pkg::BSR_PER_W,
    parameter int OFF_W = bsr_pkg::BSR_OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PER_W-1:0] period_cfg,
    input  logic [OFF_W-1:0] off_cfg,
    output logic [PER_W-1:0] cnt,
    output logic             wrap,
    output logic [PER_W-1:0] wmax
);
    localparam int MW = ((PER_W > OFF_W) ? PER_W : OFF_W) + 2;

    typedef struct packed {
        logic [PER_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [MW-1:0] plen, moff;

    always_comb begin
        tmr_d = tmr_q;
        wrap  = en && (tmr_q.cnt >= period_cfg);
        if (!en || wrap) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + PER_W'(1);
        end
        plen = MW'(period_cfg) + MW'(1);
        moff = MW'(off_cfg) + MW'(bsr_pkg::BSR_MOFF_BIAS);
        wmax = (plen > moff) ? PER_W'(plen - moff) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign cnt = tmr_q.cnt;
endmodule

// File: rtl/bsr_width_reg.sv
module bsr_width_reg #(
    parameter int PER_W = bsr_pkg::BSR_PER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wrap,
    input  logic             fb_low,
    input  logic [PER_W-1:0] wmax,
    output logic [PER_W-1:0] width
);
    typedef struct packed {
        logic [PER_W-1:0] w;
    } wst_t;

    wst_t wst_d, wst_q;
    logic [PER_W-1:0] step;

    always_comb begin
        wst_d = wst_q;
        step  = wst_q.w;
        if (fb_low) begin
            if (wst_q.w < wmax) step = wst_q.w + PER_W'(1);
        end else begin
            if (wst_q.w != '0) step = wst_q.w - PER_W'(1);
        end
        if (!en) begin
            wst_d.w = '0;
        end else if (wrap) begin
            wst_d.w = (step > wmax) ? wmax : step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wst_q <= '0;
        else        wst_q <= wst_d;
    end

    assign width = wst_q.w;

    // R4
    width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(wrap)) |-> $stable(wst_q.w));

    // R5
    width_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wrap) |-> (wst_q.w <= $past(wmax)));

    // R1
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en) |-> (wst_q.w == '0));
endmodule

// File: rtl/bsr_drive_gate.sv
module bsr_drive_gate #(
    parameter int PER_W = bsr_pkg::BSR_PER_W,
    parameter int CAL_N = bsr_pkg::BSR_CAL_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wrap,
    input  logic [PER_W-1:0] cnt,
    input  logic [PER_W-1:0] width,
    input  logic             ovl,
    input  logic             cal_req,
    output logic             drv_p,
    output logic             drv_n,
    output logic             cal_busy
);
    localparam int CCW = $clog2(CAL_N) + 1;

    typedef struct packed {
        logic           cut;
        logic           cal;
        logic [CCW-1:0] calcnt;
    } gst_t;

    gst_t gst_d, gst_q;
    logic ovl_eff;

    always_comb begin
        gst_d   = gst_q;
        ovl_eff = ovl && !gst_q.cal;
        if (!en || wrap) gst_d.cut = 1'b0;
        else             gst_d.cut = gst_q.cut | ovl_eff;

        if (!en) begin
            gst_d.cal    = 1'b0;
            gst_d.calcnt = '0;
        end else if (cal_req && !gst_q.cal) begin
            gst_d.cal    = 1'b1;
            gst_d.calcnt = '0;
        end else if (gst_q.cal && wrap) begin
            if (gst_q.calcnt == CCW'(CAL_N - 1)) begin
                gst_d.cal    = 1'b0;
                gst_d.calcnt = '0;
            end else begin
                gst_d.calcnt = gst_q.calcnt + CCW'(1);
            end
        end

        drv_p = en && (cnt < width) && !gst_q.cut && !ovl_eff;
        drv_n = !drv_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gst_q <= '0;
        else        gst_q <= gst_d;
    end

    assign cal_busy = gst_q.cal;

    // R7
    cut_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(ovl && !gst_q.cal) && !$past(wrap)) |-> !drv_p);

    // R8
    cal_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gst_q.cal) |-> ($past(wrap) || $past(!en)));
endmodule

// File: rtl/bsr_pwm_ctrl.sv
module bsr_pwm_ctrl #(
    parameter int PER_W = bsr_pkg::BSR_PER_W,
    parameter int OFF_W = bsr_pkg::BSR_OFF_W,
    parameter int CAL_N = bsr_pkg::BSR_CAL_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic [PER_W-1:0] period_cfg,
    input  logic [OFF_W-1:0] off_cfg,
    input  logic             cal_req,
    input  logic             fb_low,
    input  logic             ovl,
    output logic             drv_p,
    output logic             drv_n,
    output logic [PER_W-1:0] width_o,
    output logic             cal_busy
);
    logic             en;
    logic [PER_W-1:0] cnt;
    logic             wrap;
    logic [PER_W-1:0] wmax;
    logic [PER_W-1:0] width;

    assign en = !pwr_down;

    bsr_period_timer #(.PER_W(PER_W), .OFF_W(OFF_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(en), .period_cfg(period_cfg),
        .off_cfg(off_cfg), .cnt(cnt), .wrap(wrap), .wmax(wmax)
    );

    bsr_width_reg #(.PER_W(PER_W)) u_width (
        .clk(clk), .rst_n(rst_n), .en(en), .wrap(wrap), .fb_low(fb_low),
        .wmax(wmax), .width(width)
    );

    bsr_drive_gate #(.PER_W(PER_W), .CAL_N(CAL_N)) u_gate (
        .clk(clk), .rst_n(rst_n), .en(en), .wrap(wrap), .cnt(cnt),
        .width(width), .ovl(ovl), .cal_req(cal_req), .drv_p(drv_p),
        .drv_n(drv_n), .cal_busy(cal_busy)
    );

    assign width_o = width;
endmodule

// File: tb/bsr_pwm_ctrl_bench.sv
module bsr_pwm_ctrl_bench;
    localparam int CLK_NS = 10;
    localparam int PER_W  = 8;
    localparam int OFF_W  = 5;
    localparam int CAL_N  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwr_down = 1'b1;
    logic [PER_W-1:0] period_cfg = 8'd19;
    logic [OFF_W-1:0] off_cfg = '0;
    logic             cal_req = 1'b0;
    logic             fb_low = 1'b1;
    logic             ovl = 1'b0;
    logic             drv_p, drv_n, cal_busy;
    logic [PER_W-1:0] width_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS / 2) clk = ~clk;

    bsr_pwm_ctrl #(.PER_W(PER_W), .OFF_W(OFF_W), .CAL_N(CAL_N)) u_bsr_pwm_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .period_cfg(period_cfg),
        .off_cfg(off_cfg), .cal_req(cal_req), .fb_low(fb_low), .ovl(ovl),
        .drv_p(drv_p), .drv_n(drv_n), .width_o(width_o), .cal_busy(cal_busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // samples n consecutive cycles, returns high count and complement flag
    task automatic count_high(input int n, output int hi, output int pol_ok);
        hi = 0;
        pol_ok = 1;
        for (int i = 0; i < n; i++) begin
            if (drv_p) hi++;
            if (drv_n !== ~drv_p) pol_ok = 0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R9 drv_p", int'(drv_p), 0);
        chk("R9 drv_n", int'(drv_n), 1);
        chk("R9 width", int'(width_o), 0);
        chk("R9 cal_busy", int'(cal_busy), 0);
    endtask

    task automatic t_disabled();
        int hi, ok;
        count_high(30, hi, ok);
        chk("R1 no drive while down", hi, 0);
        chk("R1 width while down", int'(width_o), 0);
    endtask

    task automatic t_ramp_up();
        int hi, ok;
        period_cfg = 8'd19;
        off_cfg = '0;
        fb_low = 1'b1;
        pwr_down = 1'b0;
        step(5 * 20);
        chk("R4 width after 5 periods", int'(width_o), 5);
        count_high(20, hi, ok);
        chk("R3 on clocks at width 5", hi, 5);
        step(20 * 20);
        chk("R5 ceiling period 20 off 0", int'(width_o), 16);
        count_high(20, hi, ok);
        chk("R3 on clocks at width 16", hi, 16);
        chk("R6 complement", ok, 1);
    endtask

    task automatic t_ramp_down();
        int hi, ok;
        fb_low = 1'b0;
        step(3 * 20);
        chk("R4 width after 3 down steps", int'(width_o), 13);
        step(20 * 20);
        chk("R4 floor at 0", int'(width_o), 0);
        count_high(20, hi, ok);
        chk("R3 no drive at width 0", hi, 0);
    endtask

    task automatic t_min_off();
        int hi, ok;
        off_cfg = 5'd10;
        fb_low = 1'b1;
        step(20 * 20);
        chk("R5 ceiling period 20 off 10", int'(width_o), 6);
        count_high(20, hi, ok);
        chk("R5 on clocks with min off 14", hi, 6);
        chk("R6 complement", ok, 1);
    endtask

    task automatic t_overload();
        int waited, run;
        waited = 0;
        while (drv_p && waited < 100) begin step(1); waited++; end
        waited = 0;
        while (!drv_p && waited < 100) begin step(1); waited++; end
        ovl = 1'b1;
        #1;
        chk("R7 immediate cut", int'(drv_p), 0);
        step(1);
        ovl = 1'b0;
        waited = 0;
        while (!drv_p && waited < 100) begin step(1); waited++; end
        chk("R7 low until next period", waited, 19);
        run = 0;
        while (drv_p && run < 100) begin step(1); run++; end
        chk("R7 full width next period", run, 6);
    endtask

    task automatic t_calibrate();
        int hi, ok;
        cal_req = 1'b1;
        step(1);
        cal_req = 1'b0;
        chk("R8 cal_busy set", int'(cal_busy), 1);
        ovl = 1'b1;
        count_high(20, hi, ok);
        chk("R8 overload ignored in window", hi, 6);
        ovl = 1'b0;
        step(CAL_N * 20);
        chk("R8 cal_busy cleared", int'(cal_busy), 0);
        ovl = 1'b1;
        count_high(20, hi, ok);
        chk("R7 overload honoured after window", hi, 0);
        ovl = 1'b0;
        step(20);
    endtask

    task automatic t_period();
        int waited, gap, hi, ok;
        period_cfg = 8'd9;
        off_cfg = '0;
        fb_low = 1'b1;
        step(20 * 10);
        chk("R5 ceiling period 10", int'(width_o), 6);
        waited = 0;
        while (drv_p && waited < 100) begin step(1); waited++; end
        while (!drv_p && waited < 200) begin step(1); waited++; end
        gap = 0;
        while (drv_p && gap < 100) begin step(1); gap++; end
        while (!drv_p && gap < 200) begin step(1); gap++; end
        chk("R2 rise to rise spacing", gap, 10);
        count_high(10, hi, ok);
        chk("R3 on clocks period 10", hi, 6);
    endtask

    task automatic t_power_cycle();
        pwr_down = 1'b1;
        #1;
        chk("R1 drv_p off at once", int'(drv_p), 0);
        chk("R1 drv_n idle level", int'(drv_n), 1);
        step(1);
        chk("R1 width cleared", int'(width_o), 0);
        step(10);
        pwr_down = 1'b0;
        step(1);
        chk("R1 soft start width", int'(width_o), 0);
        step(9);
        chk("R1 first step after restart", int'(width_o), 1);
    endtask

    initial begin
        #(CLK_NS * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_disabled();
        t_ramp_up();
        t_ramp_down();
        t_min_off();
        t_overload();
        t_calibrate();
        t_period();
        t_power_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule